// File: doc/BRIEF.md
# Dual-Width Execute Unit

This block is the execute stage of a simple load/store pipeline. Each issued instruction carries a width flag and runs at either a narrow (16-bit) or a wide (32-bit) width. The operations are add, subtract, bitwise AND, bitwise OR, three shifts and an equality compare. Each operand has its own forwarding select, which picks the register value, the value forwarded from the memory stage or the value forwarded from write-back. The B operand can also take a sign-extended 16-bit immediate.

For narrow instructions the upper half of the datapath stays still. Each operand mux keeps the upper half it last presented, so the adder, logic and shifter see no change in their upper bits. The result register loads its upper half only on wide instructions. The store-data register loads only for store instructions. The adder is built from 4-bit lookahead groups whose group generate and propagate terms feed a second lookahead level. All outputs are registered: they change one clock edge after an issued instruction.

Top module: `dwx_exec`

## Requirements
- R1: While `rst_n` is low, `alu_res`, `carry_flag`, `eq_flag` and `store_data` are all zero.
- R2: With `wide`=1, ADD (`op_code` 0) loads `alu_res` with A+B mod 2^32 and `carry_flag` with the carry out of bit 31. SUB (`op_code` 1) loads A−B mod 2^32 and sets `carry_flag` to 1 exactly when A ≥ B unsigned.
- R3: With `wide`=0, ADD and SUB load only `alu_res[15:0]`, computed from the low 16 bits of the operands, and `carry_flag` takes the carry out of bit 15. `alu_res[31:16]` keeps its previous value, and the upper 16 bits at each operand-mux output equal those of the previous cycle.
- R4: AND (`op_code` 2) and OR (`op_code` 3) load the bitwise result over the selected width. A narrow instance leaves `alu_res[31:16]` untouched.
- R5: SLL (4), SRL (5) and SRA (6) shift A by B[4:0] when wide. When narrow they shift A[15:0] by B[3:0], and SRA fills with bit 15. A narrow shift leaves `alu_res[31:16]` untouched.
- R6: CEQ (`op_code` 7) loads `eq_flag` with A==B over 32 bits when wide, or over bits 15..0 when narrow. It leaves `alu_res` and `carry_flag` unchanged. No other instruction changes `eq_flag`.
- R7: `sel_a` picks 0 = `reg_a`, 1 = `fwd_mem`, 2 = `fwd_wb`, and 3 = `reg_a`. `sel_b` picks 0 = `reg_b`, 1 = `fwd_mem`, 2 = `fwd_wb`, and 3 = `imm` sign-extended from bit 15.
- R8: A cycle with `ex_valid`=0 changes no output.
- R9: An issued instruction with `is_store`=1 loads `store_data` with the forwarded B value, where `sel_b`=3 selects `reg_b`. It loads all 32 bits when wide and bits 15..0 only when narrow. Without `is_store`, `store_data` holds.
- R10: `carry_flag` changes only on issued ADD or SUB instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | An instruction is issued this cycle |
| op_code | input | 3 | Operation code (see R2..R6) |
| wide | input | 1 | 1 = 32-bit operation, 0 = 16-bit operation |
| sel_a | input | 2 | A operand source select |
| sel_b | input | 2 | B operand source select |
| is_store | input | 1 | Instruction is a store; latch store data |
| reg_a | input | 32 | A value read from the register file |
| reg_b | input | 32 | B value read from the register file |
| fwd_mem | input | 32 | Value forwarded from the memory stage |
| fwd_wb | input | 32 | Value forwarded from write-back |
| imm | input | 16 | Immediate field |
| alu_res | output | 32 | Registered result (EX/MEM) |
| carry_flag | output | 1 | Registered add/sub carry |
| eq_flag | output | 1 | Registered compare result |
| store_data | output | 32 | Registered store data |

## Verification
The checker watches several conditions on every cycle. It confirms that narrow instructions never disturb the upper half of the result. It confirms that the upper halves of both operand-mux outputs stay frozen during narrow and idle cycles. It also confirms that the carry, compare flag and store data move only on the instructions entitled to change them, and that idle cycles change nothing. Arithmetic values are left to the bench: sums, carries at bit 15 and bit 31, the shift results for every shift amount, the sign fill of narrow SRA, and the equality outcome when only the low halves match. The bench also covers how the forwarding selects and the immediate choice route data, which it shows by sweeping every op, width and select combination against varied data.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_SLL = 3'd4,
      OP_SRL = 3'd5,
      OP_SRA = 3'd6,
      OP_CEQ = 3'd7
   } dwx_op_e;
endpackage

// File: rtl/dwx_opsel.sv
// Operand source mux whose upper half is frozen unless a wide op issues.
module dwx_opsel #(
   parameter int W    = 32,
   parameter int NW   = 16,
   parameter int NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid,
   input  logic            wide,
   input  logic [1:0]      sel,
   input  logic [NSRC*W-1:0] src,
   output logic [W-1:0]    eff
);
   if (NSRC < 1 || NSRC > 4) begin : g_bad_nsrc
      $error("dwx_opsel: NSRC must be 1..4");
   end

   logic [W-1:0]    pick;
   logic [W-NW-1:0] hi_q;
   logic            load_hi;

   always_comb begin
      pick = src[W-1:0];
      for (int i = 1; i < NSRC; i++) begin
         if (sel == 2'(i)) pick = src[i*W +: W];
      end
   end

   assign load_hi = valid && wide;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_q <= '0;
      else if (load_hi) hi_q <= pick[W-1:NW];
   end

   assign eff = {load_hi ? pick[W-1:NW] : hi_q, pick[NW-1:0]};
endmodule

// File: rtl/dwx_cla.sv
// Two-level carry-lookahead adder: GRP-bit groups plus a group lookahead level.
module dwx_cla #(
   parameter int W   = 32,
   parameter int NW  = 16,
   parameter int GRP = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         c_narrow,
   output logic         c_wide
);
   localparam int NG = W / GRP;

   if (W % GRP != 0 || NW % GRP != 0) begin : g_bad_grp
      $error("dwx_cla: widths must be multiples of GRP");
   end

   logic [W-1:0]  g, p;
   logic [NG-1:0] gg, gp;
   logic [NG:0]   gc;

   assign g = a & b;
   assign p = a ^ b;

   for (genvar k = 0; k < NG; k++) begin : g_grp
      always_comb begin
         logic gt, pt;
         gt = 1'b0;
         pt = 1'b1;
         for (int j = 0; j < GRP; j++) begin
            gt = g[k*GRP+j] | (p[k*GRP+j] & gt);
            pt = pt & p[k*GRP+j];
         end
         gg[k] = gt;
         gp[k] = pt;
      end

      always_comb begin
         logic ci;
         ci = gc[k];
         for (int j = 0; j < GRP; j++) begin
            sum[k*GRP+j] = p[k*GRP+j] ^ ci;
            ci = g[k*GRP+j] | (p[k*GRP+j] & ci);
         end
      end
   end

   // second level: each group carry as a flat sum of products
   always_comb begin
      gc[0] = cin;
      for (int k = 1; k <= NG; k++) begin
         logic acc, term;
         acc  = cin;
         for (int m = 0; m < k; m++) acc = acc & gp[m];
         for (int j = 0; j < k; j++) begin
            term = gg[j];
            for (int m = j + 1; m < k; m++) term = term & gp[m];
            acc = acc | term;
         end
         gc[k] = acc;
      end
   end

   assign c_narrow = gc[NW/GRP];
   assign c_wide   = gc[NG];
endmodule

// File: rtl/dwx_shift.sv
// Shifter; a narrow shift passes the upper half through untouched.
module dwx_shift #(
   parameter int W  = 32,
   parameter int NW = 16
) (
   input  logic [W-1:0]         d,
   input  logic [$clog2(W)-1:0] amt,
   input  logic [1:0]           kind,   // 0 left, 1 right logical, 2 right arithmetic
   input  logic                 wide,
   output logic [W-1:0]         q
);
   localparam int NSB = $clog2(NW);

   logic [NW-1:0]  lo;
   logic [NSB-1:0] amt_n;

   assign lo    = d[NW-1:0];
   assign amt_n = amt[NSB-1:0];

   always_comb begin
      if (wide) begin
         case (kind)
            2'd0:    q = d << amt;
            2'd1:    q = d >> amt;
            default: q = W'($signed(d) >>> amt);
         endcase
      end else begin
         q[W-1:NW] = d[W-1:NW];
         case (kind)
            2'd0:    q[NW-1:0] = lo << amt_n;
            2'd1:    q[NW-1:0] = lo >> amt_n;
            default: q[NW-1:0] = NW'($signed(lo) >>> amt_n);
         endcase
      end
   end
endmodule

// File: rtl/dwx_exec.sv
module dwx_exec
   import dwx_pkg::*;
#(
   parameter int W    = 32,
   parameter int NW   = 16,
   parameter int IMMW = 16,
   parameter int GRP  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ex_valid,
   input  logic [2:0]      op_code,
   input  logic            wide,
   input  logic [1:0]      sel_a,
   input  logic [1:0]      sel_b,
   input  logic            is_store,
   input  logic [W-1:0]    reg_a,
   input  logic [W-1:0]    reg_b,
   input  logic [W-1:0]    fwd_mem,
   input  logic [W-1:0]    fwd_wb,
   input  logic [IMMW-1:0] imm,
   output logic [W-1:0]    alu_res,
   output logic            carry_flag,
   output logic            eq_flag,
   output logic [W-1:0]    store_data
);
   localparam int SHW = $clog2(W);

   if (NW >= W || (1 << SHW) != W || (1 << $clog2(NW)) != NW) begin : g_bad_width
      $error("dwx_exec: W, NW must be powers of two with NW < W");
   end
   if (IMMW > W) begin : g_bad_imm
      $error("dwx_exec: IMMW exceeds W");
   end

   dwx_op_e      op;
   logic [W-1:0] imm_ext, a_eff, b_eff, b_fwd, b_add, sum, sh, r;
   logic         is_sub, is_arith, c_narrow, c_wide, eq_now;

   assign op      = dwx_op_e'(op_code);
   assign imm_ext = {{(W-IMMW){imm[IMMW-1]}}, imm};

   dwx_opsel #(.W(W), .NW(NW), .NSRC(3)) u_opa (
      .clk(clk), .rst_n(rst_n), .valid(ex_valid), .wide(wide), .sel(sel_a),
      .src({fwd_wb, fwd_mem, reg_a}), .eff(a_eff));

   dwx_opsel #(.W(W), .NW(NW), .NSRC(4)) u_opb (
      .clk(clk), .rst_n(rst_n), .valid(ex_valid), .wide(wide), .sel(sel_b),
      .src({imm_ext, fwd_wb, fwd_mem, reg_b}), .eff(b_eff));

   // store data path: forwarding only, never the immediate
   always_comb begin
      case (sel_b)
         2'd1:    b_fwd = fwd_mem;
         2'd2:    b_fwd = fwd_wb;
         default: b_fwd = reg_b;
      endcase
   end

   assign is_sub   = (op == OP_SUB);
   assign is_arith = (op == OP_ADD) || is_sub;
   assign b_add    = is_sub ? ~b_eff : b_eff;

   dwx_cla #(.W(W), .NW(NW), .GRP(GRP)) u_add (
      .a(a_eff), .b(b_add), .cin(is_sub), .sum(sum),
      .c_narrow(c_narrow), .c_wide(c_wide));

   dwx_shift #(.W(W), .NW(NW)) u_sh (
      .d(a_eff), .amt(b_eff[SHW-1:0]), .kind(op_code[1:0]), .wide(wide), .q(sh));

   assign eq_now = wide ? (a_eff == b_eff) : (a_eff[NW-1:0] == b_eff[NW-1:0]);

   always_comb begin
      case (op)
         OP_AND:                  r = a_eff & b_eff;
         OP_OR:                   r = a_eff | b_eff;
         OP_SLL, OP_SRL, OP_SRA:  r = sh;
         default:                 r = sum;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alu_res    <= '0;
         carry_flag <= 1'b0;
         eq_flag    <= 1'b0;
         store_data <= '0;
      end else if (ex_valid) begin
         if (op == OP_CEQ) begin
            eq_flag <= eq_now;
         end else begin
            alu_res[NW-1:0] <= r[NW-1:0];
            if (wide) alu_res[W-1:NW] <= r[W-1:NW];
         end
         if (is_arith) carry_flag <= wide ? c_wide : c_narrow;
         if (is_store) begin
            store_data[NW-1:0] <= b_fwd[NW-1:0];
            if (wide) store_data[W-1:NW] <= b_fwd[W-1:NW];
         end
      end
   end
endmodule

// File: rtl/dwx_exec_chk.sv
module dwx_exec_chk #(
   parameter int W  = 32,
   parameter int NW = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ex_valid,
   input logic         wide,
   input logic         is_store,
   input logic [2:0]   op_code,
   input logic [W-1:0] alu_res,
   input logic         carry_flag,
   input logic         eq_flag,
   input logic [W-1:0] store_data,
   input logic [W-1:0] a_eff,
   input logic [W-1:0] b_eff
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R3
   res_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && !wide) |=> $stable(alu_res[W-1:NW]));

   // R3
   opa_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !(ex_valid && wide)) |-> $stable(a_eff[W-1:NW]));

   // R3
   opb_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !(ex_valid && wide)) |-> $stable(b_eff[W-1:NW]));

   // R6
   cmp_res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && op_code == 3'd7) |=> $stable(alu_res));

   // R6
   eq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ex_valid && op_code == 3'd7) |=> $stable(eq_flag));

   // R8
   idle_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid |=> ($stable(alu_res) && $stable(store_data)));

   // R9
   store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ex_valid && is_store) |=> $stable(store_data));

   // R10
   carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ex_valid && op_code[2:1] == 2'b00) |=> $stable(carry_flag));

   // R1
   always_comb begin
      if (!rst_n) begin
         reset_zero_chk: assert (alu_res == '0 && !carry_flag && !eq_flag && store_data == '0);
      end
   end
endmodule

bind dwx_exec dwx_exec_chk #(.W(W), .NW(NW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .wide(wide), .is_store(is_store),
   .op_code(op_code), .alu_res(alu_res), .carry_flag(carry_flag), .eq_flag(eq_flag),
   .store_data(store_data), .a_eff(a_eff), .b_eff(b_eff));

// File: tb/dwx_exec_test.sv
module dwx_exec_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ex_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic        wide = 1'b0;
   logic [1:0]  sel_a = '0, sel_b = '0;
   logic        is_store = 1'b0;
   logic [31:0] reg_a = '0, reg_b = '0, fwd_mem = '0, fwd_wb = '0;
   logic [15:0] imm = '0;
   logic [31:0] alu_res, store_data;
   logic        carry_flag, eq_flag;

   int checks = 0;
   int errors = 0;

   logic [31:0] exp_res = '0, exp_st = '0;
   logic        exp_c = 1'b0, exp_eq = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dwx_exec uut (
      .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .op_code(op_code), .wide(wide),
      .sel_a(sel_a), .sel_b(sel_b), .is_store(is_store), .reg_a(reg_a), .reg_b(reg_b),
      .fwd_mem(fwd_mem), .fwd_wb(fwd_wb), .imm(imm), .alu_res(alu_res),
      .carry_flag(carry_flag), .eq_flag(eq_flag), .store_data(store_data));

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string op_tag(input logic [2:0] o, input logic w);
      if (o <= 3'd1) return w ? "R2 R7" : "R3 R7";
      if (o <= 3'd3) return "R4 R7";
      if (o <= 3'd6) return "R5 R7";
      return "R6 R7";
   endfunction

   // reference model of one issued instruction, written from the requirements
   task automatic model(input logic [2:0] o, input logic w, input logic [1:0] sa,
                        input logic [1:0] sb, input logic st);
      logic [31:0] a, b, bf, rr;
      logic [32:0] s33;
      logic [16:0] s17;
      logic signed [31:0] sa32;
      logic signed [15:0] sa16;
      a  = (sa == 2'd1) ? fwd_mem : (sa == 2'd2) ? fwd_wb : reg_a;
      bf = (sb == 2'd1) ? fwd_mem : (sb == 2'd2) ? fwd_wb : reg_b;
      b  = (sb == 2'd3) ? {{16{imm[15]}}, imm} : bf;
      sa32 = a;
      sa16 = a[15:0];
      rr = exp_res;
      case (o)
         3'd0, 3'd1: begin
            if (w) begin
               s33 = (o == 3'd0) ? {1'b0, a} + {1'b0, b} : {1'b0, a} + {1'b0, ~b} + 33'd1;
               rr = s33[31:0]; exp_c = s33[32];
            end else begin
               s17 = (o == 3'd0) ? {1'b0, a[15:0]} + {1'b0, b[15:0]}
                                 : {1'b0, a[15:0]} + {1'b0, ~b[15:0]} + 17'd1;
               rr[15:0] = s17[15:0]; exp_c = s17[16];
            end
         end
         3'd2: if (w) rr = a & b; else rr[15:0] = a[15:0] & b[15:0];
         3'd3: if (w) rr = a | b; else rr[15:0] = a[15:0] | b[15:0];
         3'd4: if (w) rr = a << b[4:0]; else rr[15:0] = a[15:0] << b[3:0];
         3'd5: if (w) rr = a >> b[4:0]; else rr[15:0] = a[15:0] >> b[3:0];
         3'd6: if (w) rr = sa32 >>> b[4:0]; else rr[15:0] = sa16 >>> b[3:0];
         default: exp_eq = w ? (a == b) : (a[15:0] == b[15:0]);
      endcase
      exp_res = rr;
      if (st) begin
         exp_st[15:0] = bf[15:0];
         if (w) exp_st[31:16] = bf[31:16];
      end
   endtask

   task automatic check_all(input string tag);
      check32({tag, " result"}, alu_res, exp_res);
      check32("R10 carry", {31'd0, carry_flag}, {31'd0, exp_c});
      check32("R6 eq", {31'd0, eq_flag}, {31'd0, exp_eq});
      check32("R9 store", store_data, exp_st);
   endtask

   task automatic issue(input logic [2:0] o, input logic w, input logic [1:0] sa,
                        input logic [1:0] sb, input logic st);
      ex_valid = 1'b1; op_code = o; wide = w; sel_a = sa; sel_b = sb; is_store = st;
      model(o, w, sa, sb, st);
      @(posedge clk);
      @(negedge clk);
      check_all(op_tag(o, w));
   endtask

   task automatic idle_cycle();
      ex_valid = 1'b0; op_code = 3'($urandom); wide = 1'($urandom);
      is_store = 1'b1; sel_a = 2'($urandom); sel_b = 2'($urandom);
      reg_a = $urandom; reg_b = $urandom; fwd_mem = $urandom; imm = 16'($urandom);
      @(posedge clk);
      @(negedge clk);
      check_all("R8 idle");
   endtask

   task automatic load_data(input int rep);
      logic [31:0] v;
      case (rep)
         0: begin
            reg_a = $urandom; reg_b = $urandom; fwd_mem = $urandom;
            fwd_wb = $urandom; imm = 16'($urandom);
         end
         1: begin
            reg_a = 32'hFFFF_FFFF; reg_b = 32'h0000_0001; fwd_mem = 32'h8000_8000;
            fwd_wb = 32'h7FFF_FFFF; imm = 16'hFFFF;
         end
         2: begin
            v = 32'($signed(16'($urandom)));
            reg_a = v; reg_b = v; fwd_mem = v; fwd_wb = v; imm = v[15:0];
         end
         default: begin
            v = $urandom;
            reg_a = {16'h1234, v[15:0]}; reg_b = {16'hABCD, v[15:0]};
            fwd_mem = {16'h0F0F, v[15:0]}; fwd_wb = {16'h5A5A, v[15:0]}; imm = v[15:0];
         end
      endcase
   endtask

   initial begin
      #4_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state while reset is held
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);

      // sweep every op, width and select combination with varied data (R2..R7, R9, R10)
      for (int o = 0; o < 8; o++) begin
         for (int w = 0; w < 2; w++) begin
            for (int sa = 0; sa < 4; sa++) begin
               for (int sb = 0; sb < 4; sb++) begin
                  for (int rep = 0; rep < 4; rep++) begin
                     load_data(rep);
                     issue(3'(o), 1'(w), 2'(sa), 2'(sb), 1'(rep[0]));
                     if (rep == 3 && sb == 0) idle_cycle();  // R8
                  end
               end
            end
         end
      end

      // carry boundaries: R3 narrow carry from bit 15, R2 wide carry from bit 31
      reg_a = 32'h0000_FFFF; reg_b = 32'h0000_0001;
      issue(3'd0, 1'b0, 2'd0, 2'd0, 1'b0);
      issue(3'd0, 1'b1, 2'd0, 2'd0, 1'b0);
      reg_a = 32'hFFFF_FFFF;
      issue(3'd0, 1'b1, 2'd0, 2'd0, 1'b0);
      reg_a = 32'h0000_0000;
      issue(3'd1, 1'b0, 2'd0, 2'd0, 1'b0);

      // R5: all shift amounts, both widths, negative data, amount via immediate
      reg_a = 32'h8421_9F03;
      for (int s = 0; s < 32; s++) begin
         imm = 16'(s) | 16'hFFE0;
         for (int o = 4; o < 7; o++) begin
            issue(3'(o), 1'b1, 2'd0, 2'd3, 1'b0);
            issue(3'(o), 1'b0, 2'd0, 2'd3, 1'b0);
         end
      end

      idle_cycle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule